// File: doc/BRIEF.md
# DAC Sample Source Router

This block chooses the stereo sample stream that feeds a DAC data path. Two external deserialised streams are offered to a 2-to-1 selector driven by one control bit. A loopback control sends the ADC's parallel sample stream to the DAC input in place of the selector output. Each stream carries one 24-bit signed left/right pair per transfer and uses a valid/ready handshake.

The block also holds the DAC interface-format setting. While loopback is active it reports the ADC format instead, and it keeps the last DAC format written so that the format applies when loopback ends. After a clocking change it forces the DAC samples to zero until clean data can resume. Selection changes are applied only between frames, so a stalled frame always finishes from the stream that offered it.

Back-pressure rules: the output stream is driven combinationally from the applied source. That source's ready equals `out_ready`. Every other input's ready is held low, so an unselected source stalls. A source must keep its pair stable while its valid is high and ready is low. When it does, `out_left`/`out_right` stay stable through an output stall, except when a clocking change forces zeros.

Top module: `dac_route`

## Requirements
- R1: With loopback off, `src_sel`=0 routes input 0 and `src_sel`=1 routes input 1 to the output (valid and both samples). The selected input's ready equals `out_ready`, and the other two ready outputs are 0.
- R2: With loopback on, the ADC stream is routed to the output and `adc_ready` equals `out_ready`. Both external inputs' readies are 0, whatever `src_sel` is.
- R3: While loopback is applied, `fmt_from_adc` is 1 and `fmt_code` equals {0, `adc_fmt`}. Changes on `dac_fmt` have no effect on `fmt_code`.
- R4: When loopback is cleared, `fmt_code` shows the value present on `dac_fmt` at the edge where loopback ends. It shows this from the same cycle in which the route returns to the external inputs.
- R5: With loopback off, `fmt_code` follows `dac_fmt` one clock later, and `fmt_from_adc` is 0.
- R6: `src_sel` and `loop_en` are sampled on every rising edge where no stall is pending. A stall is pending when `out_valid` is 1 and `out_ready` is 0. A sampled setting routes from the next cycle. During a stall, the route stays on the stalled stream.
- R7: A cycle with `clk_chg` high makes output samples zero from the next cycle. The samples stay zero up to and including the first frame accepted (valid and ready) in a cycle with `clk_chg` low. Samples pass unchanged after that frame.
- R8: After reset, input 0 is routed, loopback is off, `fmt_code` is 00 and samples pass unmuted.
- R9: During an output stall with stable source data and `clk_chg` low, `out_left` and `out_right` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Input 0 frame valid |
| in0_ready | output | 1 | Input 0 frame accepted |
| in0_left | input | 24 | Input 0 left sample |
| in0_right | input | 24 | Input 0 right sample |
| in1_valid | input | 1 | Input 1 frame valid |
| in1_ready | output | 1 | Input 1 frame accepted |
| in1_left | input | 24 | Input 1 left sample |
| in1_right | input | 24 | Input 1 right sample |
| adc_valid | input | 1 | ADC frame valid |
| adc_ready | output | 1 | ADC frame accepted |
| adc_left | input | 24 | ADC left sample |
| adc_right | input | 24 | ADC right sample |
| out_valid | output | 1 | DAC frame valid |
| out_ready | input | 1 | DAC accepts frame |
| out_left | output | 24 | DAC left sample |
| out_right | output | 24 | DAC right sample |
| src_sel | input | 1 | External input select |
| loop_en | input | 1 | Loopback request |
| dac_fmt | input | 2 | DAC format field |
| adc_fmt | input | 1 | ADC format bit |
| clk_chg | input | 1 | Clocking change in progress |
| fmt_code | output | 2 | Format in effect |
| fmt_from_adc | output | 1 | Format taken from ADC bit |

## Verification
A wrong applied-route register shows on the cycle after the setting is sampled. The wrong stream's samples reach the output, and the ready goes to the wrong input. A frozen route would show as a stalled frame that changes sources before it is accepted. A wrong held format shows as a stale or ADC-derived `fmt_code` one cycle after loopback ends. A mute flag that clears too soon lets non-zero samples through on the frame right after `clk_chg` falls, and one that never clears keeps later frames at zero.

// File: rtl/dac_route_pkg.sv
package dac_route_pkg;
  localparam int FMT_W = 2;
  typedef logic [FMT_W-1:0] fmt_t;
  localparam int NSRC  = 3;
  localparam int SRC_ADC = 2;
endpackage

// File: rtl/dac_route_ctrl.sv
module dac_route_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic loop_en,
  input  logic hold,
  output logic src_q,
  output logic loop_q,
  output logic loop_nx
);
  assign loop_nx = hold ? loop_q : loop_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      loop_q <= 1'b0;
    end else if (!hold) begin
      src_q  <= src_sel;
      loop_q <= loop_en;
    end
  end

  AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(src_q) && $stable(loop_q))); // R6
endmodule

// File: rtl/dac_route_fmt.sv
module dac_route_fmt
  import dac_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loop_q,
  input  logic loop_nx,
  input  fmt_t dac_fmt,
  input  logic adc_fmt,
  output fmt_t fmt_code,
  output logic fmt_from_adc
);
  fmt_t act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        act_q <= '0;
    else if (!loop_nx) act_q <= dac_fmt;
  end

  assign fmt_from_adc = loop_q;
  assign fmt_code     = loop_q ? fmt_t'({{(FMT_W-1){1'b0}}, adc_fmt}) : act_q;

  AST_FMT_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && loop_nx) |=> $stable(act_q)); // R3
endmodule

// File: rtl/dac_route_mute.sv
module dac_route_mute (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_chg,
  input  logic xfer,
  output logic mute
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mute <= 1'b0;
    else if (clk_chg) mute <= 1'b1;
    else if (xfer)    mute <= 1'b0;
  end

  AST_MUTE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chg |=> mute); // R7
endmodule

// File: rtl/dac_route.sv
module dac_route
  import dac_route_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in0_valid,
  output logic                in0_ready,
  input  logic [SAMPLE_W-1:0] in0_left,
  input  logic [SAMPLE_W-1:0] in0_right,
  input  logic                in1_valid,
  output logic                in1_ready,
  input  logic [SAMPLE_W-1:0] in1_left,
  input  logic [SAMPLE_W-1:0] in1_right,
  input  logic                adc_valid,
  output logic                adc_ready,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  input  logic                src_sel,
  input  logic                loop_en,
  input  logic [1:0]          dac_fmt,
  input  logic                adc_fmt,
  input  logic                clk_chg,
  output logic [1:0]          fmt_code,
  output logic                fmt_from_adc
);
  localparam int IDX_W = $clog2(NSRC);

  logic                src_q, loop_q, loop_nx, mute, hold;
  logic [IDX_W-1:0]    idx;
  logic [NSRC-1:0]     v_arr, r_arr;
  logic [SAMPLE_W-1:0] l_arr [NSRC];
  logic [SAMPLE_W-1:0] r_dat [NSRC];

  assign v_arr = {adc_valid, in1_valid, in0_valid};
  assign l_arr[0] = in0_left;  assign r_dat[0] = in0_right;
  assign l_arr[1] = in1_left;  assign r_dat[1] = in1_right;
  assign l_arr[2] = adc_left;  assign r_dat[2] = adc_right;

  assign idx  = loop_q ? IDX_W'(SRC_ADC) : IDX_W'(src_q);
  assign hold = out_valid && !out_ready;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_rdy
      assign r_arr[g] = (idx == IDX_W'(g)) && out_ready;
    end
  endgenerate

  assign in0_ready = r_arr[0];
  assign in1_ready = r_arr[1];
  assign adc_ready = r_arr[2];
  assign out_valid = v_arr[idx];
  assign out_left  = mute ? '0 : l_arr[idx];
  assign out_right = mute ? '0 : r_dat[idx];

  dac_route_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .loop_en(loop_en),
    .hold(hold), .src_q(src_q), .loop_q(loop_q), .loop_nx(loop_nx)
  );

  dac_route_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .loop_q(loop_q), .loop_nx(loop_nx),
    .dac_fmt(dac_fmt), .adc_fmt(adc_fmt), .fmt_code(fmt_code),
    .fmt_from_adc(fmt_from_adc)
  );

  dac_route_mute u_mute (
    .clk(clk), .rst_n(rst_n), .clk_chg(clk_chg),
    .xfer(out_valid && out_ready), .mute(mute)
  );

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in0_ready, in1_ready, adc_ready})); // R1
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_ready || in1_ready || adc_ready) |-> out_ready); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clk_chg && !mute && $stable(in0_left) && $stable(in1_left) && $stable(adc_left))
      |=> (mute || $stable(out_left) || $past(clk_chg))); // R9
endmodule

// File: tb/dac_route_test.sv
module dac_route_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in0_valid = 0, in1_valid = 0, adc_valid = 0, out_ready = 0;
  logic [23:0] in0_left = 0, in0_right = 0, in1_left = 0, in1_right = 0;
  logic [23:0] adc_left = 0, adc_right = 0;
  logic src_sel = 0, loop_en = 0, adc_fmt = 0, clk_chg = 0;
  logic [1:0] dac_fmt = 0;
  logic in0_ready, in1_ready, adc_ready, out_valid, fmt_from_adc;
  logic [23:0] out_left, out_right;
  logic [1:0] fmt_code;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dac_route uut (.*);

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_data(input int k);
    in0_left = 24'h010000 + k[23:0]; in0_right = 24'h020000 + k[23:0];
    in1_left = 24'h030000 + k[23:0]; in1_right = 24'h040000 + k[23:0];
    adc_left = 24'h050000 + k[23:0]; adc_right = 24'h060000 + k[23:0];
  endtask

  function automatic logic [23:0] base_l(input int i, input int k);
    return 24'(24'h010000 + 24'h020000 * i + k);
  endfunction

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_data(0);
    repeat (3) step();
    rst_n = 1; #1;
    // R8 reset state
    in0_valid = 1; out_ready = 1; #1;
    chk("R8 route", {47'd0, in0_ready}, 48'd1);
    chk("R8 fmt", {46'd0, fmt_code}, 48'd0);
    chk("R8 data", {24'd0, out_left}, {24'd0, 24'h010000});
    in0_valid = 0;

    // R1 R2 sweep
    for (int lp = 0; lp < 2; lp++) begin
      for (int s = 0; s < 2; s++) begin
        in0_valid = 0; in1_valid = 0; adc_valid = 0; out_ready = 1;
        loop_en = lp[0]; src_sel = s[0];
        step();
        for (int k = 0; k < 16; k++) begin
          int idx;
          logic [2:0] vm;
          idx = lp ? 2 : s;
          vm = k[2:0];
          set_data(k);
          {adc_valid, in1_valid, in0_valid} = vm;
          out_ready = k[3];
          #2;
          chk(lp ? "R2 valid" : "R1 valid", {47'd0, out_valid}, {47'd0, vm[idx]});
          chk(lp ? "R2 ready" : "R1 ready", {45'd0, adc_ready, in1_ready, in0_ready},
              {45'd0, 3'(k[3] ? (3'b001 << idx) : 3'b000)});
          if (vm[idx])
            chk(lp ? "R2 data" : "R1 data", {out_left, out_right},
                {base_l(idx, k), 24'(base_l(idx, k) + 24'h010000)});
          in0_valid = 0; in1_valid = 0; adc_valid = 0; out_ready = 1;
          step();
        end
      end
    end

    // R5 format follows
    loop_en = 0; src_sel = 0; step();
    for (int f = 0; f < 4; f++) begin
      dac_fmt = f[1:0]; step();
      chk("R5 fmt", {45'd0, fmt_from_adc, fmt_code}, {46'd0, f[1:0]});
    end
    // R3 loop uses adc bit, dac writes deferred
    loop_en = 1; dac_fmt = 2'b01; step();
    for (int a = 0; a < 2; a++) begin
      adc_fmt = a[0]; dac_fmt = 2'(3 - a); step();
      chk("R3 fmt", {45'd0, fmt_from_adc, fmt_code}, {45'd0, 1'b1, 1'b0, a[0]});
    end
    dac_fmt = 2'b10; step();
    chk("R3 ignored", {46'd0, fmt_code}, {46'd0, 2'b01});
    // R4 exit loop applies latest write
    loop_en = 0; step();
    chk("R4 fmt", {45'd0, fmt_from_adc, fmt_code}, {45'd0, 3'b010});

    // R6 stall keeps route
    set_data(7); src_sel = 0; in0_valid = 1; in1_valid = 1; out_ready = 1; step();
    out_ready = 0; src_sel = 1; step(); step();
    chk("R6 stalled", {24'd0, out_left}, {24'd0, 24'h010007});
    chk("R9 stable", {24'd0, out_right}, {24'd0, 24'h020007});
    out_ready = 1; #1;
    chk("R6 still", {47'd0, in0_ready}, 48'd1);
    step();
    chk("R6 applied", {24'd0, out_left}, {24'd0, 24'h030007});
    loop_en = 1; out_ready = 0; adc_valid = 1; step();
    chk("R6 loop stalled", {47'd0, fmt_from_adc}, 48'd0);
    out_ready = 1; step();
    chk("R6 loop applied", {24'd0, out_left}, {24'd0, 24'h050007});
    loop_en = 0; step();

    // R7 clock change mute
    src_sel = 0; in0_valid = 1; out_ready = 1; step();
    chk("R7 pass", {24'd0, out_left}, {24'd0, 24'h010007});
    clk_chg = 1; step();
    chk("R7 zero", {out_left, out_right}, 48'd0);
    step();
    chk("R7 zero hold", {out_left, out_right}, 48'd0);
    clk_chg = 0; in0_valid = 0; step(); step();
    in0_valid = 1; #1;
    chk("R7 first frame zero", {out_left, out_right}, 48'd0);
    step();
    chk("R7 resume", {out_left, out_right}, {24'h010007, 24'h020007});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule